// File: doc/BRIEF.md
# PLL Configuration Register with Lock Timer

This block holds the configuration word of a frequency-multiplying PLL and stands in for the PLL's lock behaviour with digital logic. A write strobe with an address and a 32-bit data word loads four fields: multiplier, divider, frequency-range code and lock count. Each accepted write restarts a down-counter. The counter advances only on a slow-clock enable pulse. When the programmed count has run out, it raises a lock flag that a status register can sample.

The block decodes the stored fields for the clock logic around it. It gives the effective multiplication factor and an on/off indication for the PLL. It gives the divider value together with a mode that says whether the divider output is held at zero, bypassed or dividing. It also gives a flag for the upper frequency band. A write that carries a reserved range code is still stored, but it sets a sticky error bit. The full word can be read back at any time. Unused bits read as zero.

Top module: `pll_cfg_lock`

## Requirements
- R1: While reset is asserted, and on leaving it, the stored word, `lock` and `range_err` are all zero. The decoded outputs then show the PLL off and the divider in zero mode.
- R2: A write with `wr_en` high and `wr_addr` equal to CFG_ADDR (default 0) stores `wr_data[26:0]` at the clock edge. The fields are: divider in bits 7:0, lock count in bits 13:8, range code in bits 15:14 and multiplier in bits 26:16. From the next cycle `rd_data` shows bits 26:0 as written and bits 31:27 as zero.
- R3: A write to any other address changes neither `rd_data`, the decoded outputs, `lock` nor `range_err`.
- R4: `div_mode` is 2'b00 (output held at zero) for a divider field of 0, 2'b01 (bypass) for 1, and 2'b10 (divide) for 2 to 255. `div_value` always equals the divider field.
- R5: With a multiplier field of 0, `pll_on` is 0 and `mult_factor` is 0. With a field of 1 to 2047, `pll_on` is 1 and `mult_factor` equals the field plus one.
- R6: `lock` is low in the cycle after any accepted write, whatever its previous value.
- R7: After a write with lock count N and a nonzero multiplier, `lock` rises at the clock edge of the (N+1)-th `slow_en` pulse, counted after the write edge. It then stays high until the next accepted write. Clock cycles without `slow_en` do not advance the count, so a lock count of 0 locks on the first pulse.
- R8: While the stored multiplier field is 0, `lock` stays low whatever `slow_en` does.
- R9: A `slow_en` pulse that falls on the same edge as an accepted write is not counted toward the new lock count.
- R10: `range_hi` is 1 only for range code 2'b10; code 2'b00 is the lower band. A stored write with code 2'b01 or 2'b11 sets `range_err` at that edge, and it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_en | input | 1 | One-cycle enable marking a slow-clock period |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored configuration word, unused bits zero |
| pll_on | output | 1 | Multiplier field is nonzero |
| mult_factor | output | 12 | Multiplier field plus one, or zero when the PLL is off |
| div_mode | output | 2 | Divider mode: 00 zero, 01 bypass, 10 divide |
| div_value | output | 8 | Stored divider field |
| range_hi | output | 1 | Upper frequency band selected |
| range_err | output | 1 | Sticky flag for a reserved range code |
| lock | output | 1 | Modelled PLL lock flag |

## Verification
The assertions assume that `slow_en` and `wr_en` are clean single-bit levels that are sampled on the block's clock. They also assume that `slow_en` comes as separate one-cycle pulses, not as a free-running clock. The stimulus drives every input half a period away from the sampling edge. `slow_en` is asserted in roughly half of the cycles, and writes are spread far enough apart that many lock counts run to completion. Some writes land on a foreign address, some clear the multiplier, some carry a reserved range code, and some coincide with a `slow_en` pulse, so each rule the assertions rely on gets exercised at its edges.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned LCNT_W = 6;
  localparam int unsigned RNG_W  = 2;
  localparam int unsigned MUL_W  = 11;
  localparam int unsigned CFG_W  = DIV_W + LCNT_W + RNG_W + MUL_W;
  localparam int unsigned FACT_W = MUL_W + 1;

  // Field order is the bit layout: multiplier on top, divider at bit 0.
  typedef struct packed {
    logic [MUL_W-1:0]  mult;
    logic [RNG_W-1:0]  range;
    logic [LCNT_W-1:0] lcnt;
    logic [DIV_W-1:0]  div;
  } pll_cfg_t;

  typedef enum logic [1:0] {
    DIV_ZERO   = 2'b00,
    DIV_BYPASS = 2'b01,
    DIV_ACTIVE = 2'b10
  } div_mode_e;

  typedef enum logic [1:0] {
    LK_IDLE   = 2'b00,
    LK_COUNT  = 2'b01,
    LK_LOCKED = 2'b10
  } lock_state_e;

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
  import pll_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              load,
  output pll_cfg_t          cfg_nxt,
  output pll_cfg_t          cfg_q,
  output logic              range_err_q
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_ADDR);

  pll_cfg_t cfg_in;
  logic     err_nxt;
  logic     reserved_rng;

  assign cfg_in       = pll_cfg_t'(wr_data[CFG_W-1:0]);
  assign load         = wr_en && (wr_addr == HIT_ADDR);
  assign reserved_rng = cfg_in.range[0];

  always_comb begin
    cfg_nxt = cfg_q;
    err_nxt = range_err_q;
    if (load) begin
      cfg_nxt = cfg_in;
      if (reserved_rng) begin
        err_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      range_err_q <= 1'b0;
    end else begin
      cfg_q       <= cfg_nxt;
      range_err_q <= err_nxt;
    end
  end

  // R3
  ignore_other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != HIT_ADDR)) |=> $stable(cfg_q));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err_q |=> range_err_q);

  // R10
  err_on_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wr_data[14]) |=> range_err_q);

endmodule

// File: rtl/pll_field_decode.sv
module pll_field_decode
  import pll_cfg_pkg::*;
(
  input  pll_cfg_t          cfg,
  output logic              pll_on,
  output logic [FACT_W-1:0] mult_factor,
  output div_mode_e         div_mode,
  output logic [DIV_W-1:0]  div_value,
  output logic              range_hi
);

  always_comb begin
    pll_on      = (cfg.mult != '0);
    mult_factor = pll_on ? ({1'b0, cfg.mult} + FACT_W'(1)) : '0;
    div_value   = cfg.div;
    range_hi    = (cfg.range == 2'b10);
    if (cfg.div == '0) begin
      div_mode = DIV_ZERO;
    end else if (cfg.div == DIV_W'(1)) begin
      div_mode = DIV_BYPASS;
    end else begin
      div_mode = DIV_ACTIVE;
    end
  end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
  import pll_cfg_pkg::*;
#(
  parameter int unsigned CNT_W = LCNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic             load,
  input  logic             load_on,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             pll_active,
  output logic             lock
);

  lock_state_e      state_q, state_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    if (load) begin
      cnt_nxt   = load_cnt;
      state_nxt = load_on ? LK_COUNT : LK_IDLE;
    end else if ((state_q == LK_COUNT) && slow_en) begin
      if (cnt_q == '0) begin
        state_nxt = LK_LOCKED;
      end else begin
        cnt_nxt = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

  assign lock = (state_q == LK_LOCKED);

  // R6
  lock_clr_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !lock);

  // R8
  off_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_active |-> !lock);

  // R7
  lock_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(slow_en));

  // R7
  count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_en && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock
  import pll_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              pll_on,
  output logic [11:0]       mult_factor,
  output logic [1:0]        div_mode,
  output logic [7:0]        div_value,
  output logic              range_hi,
  output logic              range_err,
  output logic              lock
);

  logic      rst_int_n;
  logic      load;
  pll_cfg_t  cfg_nxt;
  pll_cfg_t  cfg_q;
  div_mode_e mode;

  pll_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pll_cfg_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg_reg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .load        (load),
    .cfg_nxt     (cfg_nxt),
    .cfg_q       (cfg_q),
    .range_err_q (range_err)
  );

  pll_field_decode u_decode (
    .cfg         (cfg_q),
    .pll_on      (pll_on),
    .mult_factor (mult_factor),
    .div_mode    (mode),
    .div_value   (div_value),
    .range_hi    (range_hi)
  );

  pll_lock_timer #(.CNT_W(LCNT_W)) u_lock_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .slow_en    (slow_en),
    .load       (load),
    .load_on    (cfg_nxt.mult != '0),
    .load_cnt   (cfg_nxt.lcnt),
    .pll_active (pll_on),
    .lock       (lock)
  );

  assign div_mode = mode;
  assign rd_data  = {{(WORD_W-CFG_W){1'b0}}, cfg_q};

endmodule

// File: tb/pll_cfg_lock_tb.sv
module pll_cfg_lock_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pll_on;
  logic [11:0] mult_factor;
  logic [1:0]  div_mode;
  logic [7:0]  div_value;
  logic        range_hi;
  logic        range_err;
  logic        lock;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [26:0] m_cfg = '0;
  bit          m_err = 0;
  int          m_state = 0;  // 0 idle, 1 counting, 2 locked
  int          m_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  pll_cfg_lock u_dut (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .pll_on(pll_on), .mult_factor(mult_factor), .div_mode(div_mode),
    .div_value(div_value), .range_hi(range_hi), .range_err(range_err),
    .lock(lock)
  );

  function automatic logic [1:0] f_mode(input logic [7:0] d);
    if (d == 0) return 2'b00;
    if (d == 1) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [11:0] f_factor(input logic [10:0] m);
    if (m == 0) return 12'd0;
    return {1'b0, m} + 12'd1;
  endfunction

  function automatic logic [31:0] mk(input int mult, input int rng,
                                     input int lcnt, input int div);
    return {5'b0, 11'(mult), 2'(rng), 6'(lcnt), 8'(div)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 rd_data", rd_data, {5'b0, m_cfg});
    chk("R4 div_mode", 32'(div_mode), 32'(f_mode(m_cfg[7:0])));
    chk("R4 div_value", 32'(div_value), 32'(m_cfg[7:0]));
    chk("R5 mult_factor", 32'(mult_factor), 32'(f_factor(m_cfg[26:16])));
    chk("R5 pll_on", 32'(pll_on), 32'(m_cfg[26:16] != 0));
    chk("R10 range_hi", 32'(range_hi), 32'(m_cfg[15:14] == 2'b10));
    chk("R10 range_err", 32'(range_err), 32'(m_err));
    chk("R6 R7 R8 R9 lock", 32'(lock), 32'(m_state == 2));
  endtask

  // One cycle: drive at negedge, advance model at posedge, check at next negedge.
  task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d, input bit se);
    wr_en = we; wr_addr = a; wr_data = d; slow_en = se;
    @(posedge clk);
    if (we && a == 4'd0) begin
      m_cfg = d[26:0];
      if (d[14]) m_err = 1;
      m_cnt = int'(d[13:8]);
      m_state = (d[26:16] != 0) ? 1 : 0;
    end else if (m_state == 1 && se) begin
      if (m_cnt == 0) m_state = 2;
      else m_cnt--;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    // R1 reset state while asserted
    check_all();
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0);
    // R1 after release
    chk("R1 lock", 32'(lock), 0);

    // R7: lock count 0 locks on first pulse
    step(1, 0, mk(5, 0, 0, 1), 0);
    step(0, 0, 0, 0);
    chk("R7 no lock before pulse", 32'(lock), 0);
    step(0, 0, 0, 1);
    chk("R7 lcnt0 first pulse", 32'(lock), 1);

    // R6/R9: write with a pulse on the same edge; count 2 needs three more pulses
    step(1, 0, mk(100, 2, 2, 7), 1);
    chk("R6 cleared by write", 32'(lock), 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk("R9 pulse at write not counted", 32'(lock), 0);
    step(0, 0, 0, 1);
    chk("R7 lock after N+1 pulses", 32'(lock), 1);

    // R3: foreign address leaves everything, lock included
    step(1, 4'd3, mk(0, 1, 9, 0), 1);
    chk("R3 lock kept", 32'(lock), 1);
    chk("R3 err kept", 32'(range_err), 0);

    // R8: multiplier 0 never locks
    step(1, 0, mk(0, 0, 0, 0), 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
    chk("R8 off no lock", 32'(lock), 0);

    // R4/R5 extremes, R10 reserved codes and upper band
    step(1, 0, mk(2047, 3, 63, 255), 0);
    chk("R10 reserved sets err", 32'(range_err), 1);
    step(1, 0, 32'hFFFF_FFFF, 0);
    chk("R2 unused bits zero", rd_data[31:27], 0);
    step(1, 0, mk(1, 2, 1, 2), 0);
    chk("R10 err sticky", 32'(range_err), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [3:0] a;
      logic [31:0] d;
      we = ($urandom % 20) == 0;
      a  = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      d  = $urandom;
      if (($urandom % 4) == 0) d[26:16] = '0;
      if (($urandom % 3) != 0) d[13:8] = 6'($urandom % 8);
      step(we, a, d, ($urandom % 2) == 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule